// File: doc/BRIEF.md
# AAL2 CPS-Packet Header Assembly Controller

This block is one step in the transmit path of a multi-channel AAL2 engine. An upstream stage presents a finished payload. It supplies the channel index, the payload length and a per-packet 5-bit UUI byte, plus a raw-mode flag with a pre-built header. The controller reads that channel's 32-byte context from a 16-bit context memory. It then decides whether the packet may leave. If it may, it builds the 3-byte CPS-Packet header, presents the header with the destination VC number to the VC queue, and writes the updated context back.

A 4-bit start-up delete count suppresses the first packets of a channel. The value 0 means send. The value 15 means never send. Any value from 1 to 14 discards one packet and decrements the count. A 3-bit increment mode chooses how many low bits of the configured UUI are replaced by the running packet count. Instead, it can take the UUI from the per-packet byte. Two 32-bit statistics, payload bytes and packets sent, are held in the context and advanced on every packet that is sent.

The context of channel `c` starts at byte address `BASE + 32*c`. BASE is 0x1000, 0x2000, 0x4000 or 0x8000 for a channel count of 128, 256, 512 or 1023. The memory returns read data one cycle after a read strobe.

Top module: `aal2_hdr_assembler`

## Requirements
- R1: After reset, reqReady is 1 while hdrValid, errSticky, ctxRdEn and ctxWrEn are 0.
- R2: Every context access addresses byte `BASE + 32*chan + offset`. The offsets are: 0 for word A (VC in bits 15:6, delete count in bits 3:0), 2 for word B (CID in bits 15:8, increment mode in bits 6:4, configured UUI in bits 3:0), 0x18/0x1A for the byte counter high/low, and 0x1C/0x1E for the packet counter high/low.
- R3: With a delete count of 0, a packet is sent. Its header is {CID[23:16], LI[15:10], UUI[9:5], HEC[4:0]=0}, where LI is the payload length minus one (length 1 to 64). hdrVc carries the VC from word A.
- R4: With a delete count of 1 to 14, no header is issued. Only word A is rewritten, holding the count minus one with all other bits kept. The counters stay untouched.
- R5: With a delete count of 15, no header is issued and nothing is written.
- R6: Increment modes 0, 1, 2 and 3 replace the low 4, 3, 2 and 1 bits of the configured UUI with the same bits of the packet counter as read, before its increment. UUI bit 4 is 0.
- R7: Increment mode 4 sends {0, configured UUI}.
- R8: Increment mode 5 sends the 5-bit per-packet UUI input.
- R9: Increment modes 6 and 7 drop the packet and write nothing. They set errSticky, which stays 1 until reset.
- R10: In raw mode the header equals reqRawHdr unchanged and the increment mode is ignored. Delete count, VC and statistics still apply, and the byte counter uses the raw header's LI field.
- R11: A sent packet adds LI+1 to the 32-bit byte counter and 1 to the 32-bit packet counter, each wrapping modulo 2^32. The four counter words are written back in the order byte high, byte low, packet high, packet low.
- R12: hdrValid is a one-cycle pulse on the 8th clock edge after the accepting edge. reqReady is 0 from acceptance until write-back ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Packet request present |
| reqReady | output | 1 | Controller idle, request accepted when both high |
| reqChan | input | CH_W | Channel index |
| reqLen | input | 7 | Payload length, 1 to 64 |
| reqUui | input | 5 | Per-packet UUI used by increment mode 5 |
| reqRaw | input | 1 | Raw mode, header supplied whole |
| reqRawHdr | input | 24 | Header used in raw mode |
| ctxRdEn | output | 1 | Context read strobe |
| ctxWrEn | output | 1 | Context write strobe |
| ctxAddr | output | ADDR_W | Context byte address |
| ctxWrData | output | 16 | Context write data |
| ctxRdData | input | 16 | Context read data, one cycle after ctxRdEn |
| hdrValid | output | 1 | Header pulse to VC queue |
| hdrVc | output | 10 | Destination VC number |
| hdrWord | output | 24 | CPS-Packet header |
| errSticky | output | 1 | Reserved increment mode seen |

## Verification
Two functions can act on the same packet. UUI counter substitution reads the packet counter at the moment the statistics update advances it, so the emitted UUI must carry the pre-increment value while the written counter carries the incremented one. The bench provokes this with a packet counter preloaded at 0xFFFFFFFF in mode 0. That packet must carry UUI low bits 0xF and write back 0x00000000, with the byte counter carrying across its halves. The delete path and the reserved-mode check also meet in one decision. A channel with a nonzero delete count and a reserved mode must decrement quietly without raising the error flag, and that case is judged from the port-level write count and from errSticky.

// File: rtl/aal2_hdr_pkg.sv
package aal2_hdr_pkg;

  typedef enum logic [1:0] {
    ACT_DROP   = 2'd0,
    ACT_DELETE = 2'd1,
    ACT_SEND   = 2'd2,
    ACT_ERR    = 2'd3
  } hdrAction_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_CAP  = 3'd2,
    ST_DEC  = 3'd3,
    ST_WR   = 3'd4
  } hdrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capEn;
    logic [2:0] capIdx;
    logic       decide;
    logic       wrEn;
    logic [2:0] wrIdx;
  } hdrCtl_t;

  // context word slots
  localparam logic [2:0] SLOT_A     = 3'd0;
  localparam logic [2:0] SLOT_B     = 3'd1;
  localparam logic [2:0] SLOT_BYTHI = 3'd2;
  localparam logic [2:0] SLOT_BYTLO = 3'd3;
  localparam logic [2:0] SLOT_PKTHI = 3'd4;
  localparam logic [2:0] SLOT_PKTLO = 3'd5;

  localparam int CTX_BYTES = 32;

  function automatic logic [4:0] slotOffset(input logic [2:0] slot);
    case (slot)
      SLOT_A:     slotOffset = 5'h00;
      SLOT_B:     slotOffset = 5'h02;
      SLOT_BYTHI: slotOffset = 5'h18;
      SLOT_BYTLO: slotOffset = 5'h1A;
      SLOT_PKTHI: slotOffset = 5'h1C;
      default:    slotOffset = 5'h1E;
    endcase
  endfunction

  function automatic int ctxBase(input int chans);
    if (chans <= 128)      ctxBase = 32'h1000;
    else if (chans <= 256) ctxBase = 32'h2000;
    else if (chans <= 512) ctxBase = 32'h4000;
    else                   ctxBase = 32'h8000;
  endfunction

endpackage

// File: rtl/aal2_hdr_ctrl.sv
module aal2_hdr_ctrl
  import aal2_hdr_pkg::*;
#(
  parameter int CHANNELS = 128,
  parameter int ADDR_W   = 16,
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CH_W-1:0]   reqChan,
  input  hdrAction_t        action,
  output logic              reqReady,
  output logic              accept,
  output logic              ctxRdEn,
  output logic              ctxWrEn,
  output logic [ADDR_W-1:0] ctxAddr,
  output hdrCtl_t           ctl
);

  localparam int BASE_I = ctxBase(CHANNELS);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_I);
  localparam int SPAN = CHANNELS * CTX_BYTES;

  hdrState_t       state;
  logic [2:0]      idx;
  logic [2:0]      wrLast;
  logic [CH_W-1:0] chanQ;
  logic            capEnQ;
  logic [2:0]      capIdxQ;
  logic [4:0]      offNow;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;
  assign ctxRdEn  = (state == ST_READ);
  assign ctxWrEn  = (state == ST_WR);
  assign offNow   = slotOffset(idx);
  assign ctxAddr  = BASE + (ADDR_W'(chanQ) << 5) + ADDR_W'(offNow);

  always_comb begin
    ctl.capEn  = capEnQ;
    ctl.capIdx = capIdxQ;
    ctl.decide = (state == ST_DEC);
    ctl.wrEn   = (state == ST_WR);
    ctl.wrIdx  = idx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      wrLast  <= '0;
      chanQ   <= '0;
      capEnQ  <= 1'b0;
      capIdxQ <= '0;
    end else begin
      capEnQ  <= (state == ST_READ);
      capIdxQ <= idx;
      case (state)
        ST_IDLE: if (reqValid) begin
          chanQ <= reqChan;
          idx   <= SLOT_A;
          state <= ST_READ;
        end
        ST_READ: begin
          if (idx == SLOT_PKTLO) state <= ST_CAP;
          else                   idx   <= idx + 3'd1;
        end
        ST_CAP: state <= ST_DEC;
        ST_DEC: begin
          case (action)
            ACT_DELETE: begin
              idx    <= SLOT_A;
              wrLast <= SLOT_A;
              state  <= ST_WR;
            end
            ACT_SEND: begin
              idx    <= SLOT_BYTHI;
              wrLast <= SLOT_PKTLO;
              state  <= ST_WR;
            end
            default: state <= ST_IDLE;
          endcase
        end
        ST_WR: begin
          if (idx == wrLast) state <= ST_IDLE;
          else               idx   <= idx + 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: memory port never reads and writes together
  p_port_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctxRdEn, ctxWrEn}));

  // R2: every access stays within the configured context region
  p_addr_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctxRdEn || ctxWrEn) |-> (int'(ctxAddr) >= BASE_I && int'(ctxAddr) < BASE_I + SPAN));

  // R12: an accepted request leaves the idle state on the next cycle
  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

endmodule

// File: rtl/aal2_hdr_dp.sv
module aal2_hdr_dp
  import aal2_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accept,
  input  logic [6:0]  reqLen,
  input  logic [4:0]  reqUui,
  input  logic        reqRaw,
  input  logic [23:0] reqRawHdr,
  input  logic [15:0] ctxRdData,
  input  hdrCtl_t     ctl,
  output hdrAction_t  action,
  output logic [15:0] ctxWrData,
  output logic        hdrValid,
  output logic [9:0]  hdrVc,
  output logic [23:0] hdrWord,
  output logic        errSticky
);

  logic [6:0]  lenQ;
  logic [4:0]  uuiQ;
  logic        rawQ;
  logic [23:0] rawHdrQ;

  logic [15:0] wordA, wordB;
  logic [31:0] bytCnt, pktCnt;

  logic [3:0]  delCnt;
  logic [2:0]  incMode;
  logic [3:0]  cfgUui;
  logic [7:0]  cid;
  logic [5:0]  liField;
  logic [3:0]  subMask;
  logic [4:0]  uuiOut;
  logic [23:0] hdrNext;
  logic [31:0] liPlusOne;

  assign delCnt  = wordA[3:0];
  assign incMode = wordB[6:4];
  assign cfgUui  = wordB[3:0];
  assign cid     = wordB[15:8];
  assign liField = rawQ ? rawHdrQ[15:10] : 6'(lenQ - 7'd1);
  assign liPlusOne = 32'(liField) + 32'd1;

  // modes 0..3 substitute 4..1 low bits from the packet count
  always_comb begin
    subMask = 4'h0;
    if (!incMode[2]) subMask = 4'hF >> incMode[1:0];
  end

  always_comb begin
    if (incMode == 3'd5) uuiOut = uuiQ;
    else uuiOut = {1'b0, (cfgUui & ~subMask) | (pktCnt[3:0] & subMask)};
  end

  assign hdrNext = rawQ ? rawHdrQ : {cid, liField, uuiOut, 5'b0};

  always_comb begin
    if (delCnt == 4'hF)                 action = ACT_DROP;
    else if (delCnt != 4'h0)            action = ACT_DELETE;
    else if (!rawQ && incMode[2:1] == 2'b11) action = ACT_ERR;
    else                                action = ACT_SEND;
  end

  always_comb begin
    case (ctl.wrIdx)
      SLOT_A:     ctxWrData = wordA;
      SLOT_BYTHI: ctxWrData = bytCnt[31:16];
      SLOT_BYTLO: ctxWrData = bytCnt[15:0];
      SLOT_PKTHI: ctxWrData = pktCnt[31:16];
      SLOT_PKTLO: ctxWrData = pktCnt[15:0];
      default:    ctxWrData = wordB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ      <= '0;
      uuiQ      <= '0;
      rawQ      <= 1'b0;
      rawHdrQ   <= '0;
      wordA     <= '0;
      wordB     <= '0;
      bytCnt    <= '0;
      pktCnt    <= '0;
      hdrValid  <= 1'b0;
      hdrVc     <= '0;
      hdrWord   <= '0;
      errSticky <= 1'b0;
    end else begin
      hdrValid <= 1'b0;
      if (accept) begin
        lenQ    <= reqLen;
        uuiQ    <= reqUui;
        rawQ    <= reqRaw;
        rawHdrQ <= reqRawHdr;
      end
      if (ctl.capEn) begin
        case (ctl.capIdx)
          SLOT_A:     wordA          <= ctxRdData;
          SLOT_B:     wordB          <= ctxRdData;
          SLOT_BYTHI: bytCnt[31:16]  <= ctxRdData;
          SLOT_BYTLO: bytCnt[15:0]   <= ctxRdData;
          SLOT_PKTHI: pktCnt[31:16]  <= ctxRdData;
          default:    pktCnt[15:0]   <= ctxRdData;
        endcase
      end
      if (ctl.decide) begin
        case (action)
          ACT_SEND: begin
            hdrValid <= 1'b1;
            hdrWord  <= hdrNext;
            hdrVc    <= wordA[15:6];
            bytCnt   <= bytCnt + liPlusOne;
            pktCnt   <= pktCnt + 32'd1;
          end
          ACT_DELETE: wordA[3:0] <= delCnt - 4'd1;
          ACT_ERR:    errSticky  <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R12: header strobe lasts one cycle
  p_hdr_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> !hdrValid);

  // R9: error flag never clears without reset
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R3: headers only leave a channel whose delete count is zero
  p_send_zero_del_r3: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> (delCnt == 4'h0));

  // R10: raw header goes out untouched
  p_raw_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && rawQ) |-> (hdrWord == rawHdrQ));

  // R6: UUI bit 4 is zero whenever the configured UUI is used
  p_uui_msb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !rawQ && incMode != 3'd5) |-> (hdrWord[9] == 1'b0));

  // R4: a deletion lowers the stored count by exactly one
  p_del_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.decide && action == ACT_DELETE) |=> (delCnt == $past(delCnt) - 4'd1));

endmodule

// File: rtl/aal2_hdr_assembler.sv
module aal2_hdr_assembler
  import aal2_hdr_pkg::*;
#(
  parameter int CHANNELS = 128,
  parameter int ADDR_W   = 16,
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CH_W-1:0]   reqChan,
  input  logic [6:0]        reqLen,
  input  logic [4:0]        reqUui,
  input  logic              reqRaw,
  input  logic [23:0]       reqRawHdr,
  output logic              ctxRdEn,
  output logic              ctxWrEn,
  output logic [ADDR_W-1:0] ctxAddr,
  output logic [15:0]       ctxWrData,
  input  logic [15:0]       ctxRdData,
  output logic              hdrValid,
  output logic [9:0]        hdrVc,
  output logic [23:0]       hdrWord,
  output logic              errSticky
);

  hdrCtl_t    ctl;
  hdrAction_t action;
  logic       accept;

  aal2_hdr_ctrl #(.CHANNELS(CHANNELS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .action(action), .reqReady(reqReady), .accept(accept),
    .ctxRdEn(ctxRdEn), .ctxWrEn(ctxWrEn), .ctxAddr(ctxAddr), .ctl(ctl)
  );

  aal2_hdr_dp uDp (
    .clk(clk), .rstN(rstN), .accept(accept), .reqLen(reqLen),
    .reqUui(reqUui), .reqRaw(reqRaw), .reqRawHdr(reqRawHdr),
    .ctxRdData(ctxRdData), .ctl(ctl), .action(action),
    .ctxWrData(ctxWrData), .hdrValid(hdrValid), .hdrVc(hdrVc),
    .hdrWord(hdrWord), .errSticky(errSticky)
  );

endmodule

// File: tb/tb_aal2_hdr_assembler.sv
module tb_aal2_hdr_assembler;

  localparam int CHANNELS = 128;
  localparam int BASE = 32'h1000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [6:0]  reqChan;
  logic [6:0]  reqLen;
  logic [4:0]  reqUui;
  logic        reqRaw;
  logic [23:0] reqRawHdr;
  logic        ctxRdEn, ctxWrEn;
  logic [15:0] ctxAddr, ctxWrData;
  logic [15:0] ctxRdData;
  logic        hdrValid;
  logic [9:0]  hdrVc;
  logic [23:0] hdrWord;
  logic        errSticky;

  always #5 clk = ~clk;

  aal2_hdr_assembler #(.CHANNELS(CHANNELS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqChan(reqChan), .reqLen(reqLen), .reqUui(reqUui), .reqRaw(reqRaw),
    .reqRawHdr(reqRawHdr), .ctxRdEn(ctxRdEn), .ctxWrEn(ctxWrEn),
    .ctxAddr(ctxAddr), .ctxWrData(ctxWrData), .ctxRdData(ctxRdData),
    .hdrValid(hdrValid), .hdrVc(hdrVc), .hdrWord(hdrWord), .errSticky(errSticky)
  );

  logic [15:0] mem [int];
  logic [15:0] expMem [int];
  int wrCount;
  int vecCnt = 0;
  int missCnt = 0;
  bit expErr = 0;

  always @(posedge clk) begin
    if (ctxRdEn) ctxRdData <= mem.exists(int'(ctxAddr)) ? mem[int'(ctxAddr)] : 16'h0;
    if (ctxWrEn) begin
      mem[int'(ctxAddr)] = ctxWrData;
      wrCount++;
    end
  end

  function automatic logic [15:0] expRd(input int a);
    return expMem.exists(a) ? expMem[a] : 16'h0;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    vecCnt++;
    if (act != exp) begin
      missCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setCtx(input int ch, input int vc, input int del, input int cid,
                        input int mode, input int cuui, input logic [31:0] byt,
                        input logic [31:0] pkt);
    int a = BASE + 32 * ch;
    logic [15:0] wa = 16'((vc << 6) | (3 << 4) | del);
    logic [15:0] wb = 16'((cid << 8) | 16'h80 | (mode << 4) | cuui);
    mem[a] = wa;            expMem[a] = wa;
    mem[a + 2] = wb;        expMem[a + 2] = wb;
    mem[a + 24] = byt[31:16]; expMem[a + 24] = byt[31:16];
    mem[a + 26] = byt[15:0];  expMem[a + 26] = byt[15:0];
    mem[a + 28] = pkt[31:16]; expMem[a + 28] = pkt[31:16];
    mem[a + 30] = pkt[15:0];  expMem[a + 30] = pkt[15:0];
  endtask

  // reference model for one packet, then cycle-by-cycle compare
  task automatic doPkt(input string req, input int ch, input int len, input int pUui,
                       input bit raw, input logic [23:0] rawHdr);
    int a = BASE + 32 * ch;
    logic [15:0] wa = expRd(a);
    logic [15:0] wb = expRd(a + 2);
    logic [31:0] byt = {expRd(a + 24), expRd(a + 26)};
    logic [31:0] pkt = {expRd(a + 28), expRd(a + 30)};
    int del = int'(wa[3:0]);
    int mode = int'(wb[6:4]);
    bit send = 0;
    int expWr = 0;
    int li;
    logic [4:0] uui;
    logic [23:0] expHdr;
    int kept;

    li = raw ? int'(rawHdr[15:10]) : len - 1;
    if (mode == 5) uui = 5'(pUui);
    else begin
      kept = (mode <= 3) ? 4 - mode : 0;
      uui = {1'b0, wb[3:0]};
      for (int i = 0; i < 4; i++) if (i < kept) uui[i] = pkt[i];
    end
    expHdr = raw ? rawHdr : {wb[15:8], 6'(li), uui, 5'd0};

    if (del == 15) begin
    end else if (del != 0) begin
      expMem[a] = {wa[15:4], 4'(del - 1)};
      expWr = 1;
    end else if (!raw && mode >= 6) begin
      expErr = 1;
    end else begin
      send = 1;
      expWr = 4;
      byt = byt + 32'(li + 1);
      pkt = pkt + 1;
      expMem[a + 24] = byt[31:16];
      expMem[a + 26] = byt[15:0];
      expMem[a + 28] = pkt[31:16];
      expMem[a + 30] = pkt[15:0];
    end

    @(negedge clk);
    check("R12", "ready before request", reqReady, 1);
    reqValid = 1; reqChan = 7'(ch); reqLen = 7'(len); reqUui = 5'(pUui);
    reqRaw = raw; reqRawHdr = rawHdr;
    wrCount = 0;
    @(negedge clk);
    reqValid = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) check("R12", "ready during work", reqReady, 0);
      check(req, $sformatf("hdrValid cycle %0d", k), hdrValid, (send && k == 8) ? 1 : 0);
      if (send && k == 8) begin
        check(req, "header", hdrWord, expHdr);
        check("R3", "vc", hdrVc, wa[15:6]);
      end
    end
    check("R12", "ready after work", reqReady, 1);
    check(req, "write count", wrCount, expWr);
    foreach (expMem[x]) if (x >= a && x < a + 32)
      check(req, $sformatf("ctx word %0h", x), mem[x], expMem[x]);
    check("R9", "errSticky", errSticky, expErr);
  endtask

  initial begin
    #2_000_000;
    missCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    rstN = 0; reqValid = 0; reqChan = 0; reqLen = 1; reqUui = 0;
    reqRaw = 0; reqRawHdr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reqReady", reqReady, 1);
    check("R1", "hdrValid", hdrValid, 0);
    check("R1", "errSticky", errSticky, 0);
    check("R1", "strobes", {ctxRdEn, ctxWrEn}, 0);

    // R7 mode 4, plain send, R3 header layout
    setCtx(3, 10'h155, 0, 8'h21, 4, 4'hA, 32'd100, 32'h1235);
    doPkt("R7", 3, 20, 0, 0, 0);
    // R6 all counter widths, pre-increment count
    setCtx(4, 10'h3FF, 0, 8'h40, 0, 4'h0, 32'd0, 32'h0000_1235);
    doPkt("R6", 4, 5, 0, 0, 0);
    setCtx(5, 10'h001, 0, 8'h41, 1, 4'hF, 32'd0, 32'h0000_0002);
    doPkt("R6", 5, 6, 0, 0, 0);
    setCtx(6, 10'h002, 0, 8'h42, 2, 4'hC, 32'd0, 32'h0000_0007);
    doPkt("R6", 6, 7, 0, 0, 0);
    setCtx(7, 10'h003, 0, 8'h43, 3, 4'h6, 32'd0, 32'h0000_0001);
    doPkt("R6", 7, 8, 0, 0, 0);
    doPkt("R6", 7, 8, 0, 0, 0);
    // R8 per-packet UUI
    setCtx(8, 10'h0AA, 0, 8'h7E, 5, 4'h3, 32'd9, 32'd9);
    doPkt("R8", 8, 33, 5'h1B, 0, 0);
    // R4 two deletions then send
    setCtx(9, 10'h123, 2, 8'h09, 4, 4'h5, 32'd50, 32'd5);
    doPkt("R4", 9, 10, 0, 0, 0);
    doPkt("R4", 9, 10, 0, 0, 0);
    doPkt("R3", 9, 10, 0, 0, 0);
    // R5 never send
    setCtx(10, 10'h0F0, 15, 8'h10, 4, 4'h1, 32'd1, 32'd1);
    doPkt("R5", 10, 12, 0, 0, 0);
    // R4 deletion with reserved mode raises no error
    setCtx(11, 10'h011, 1, 8'h11, 6, 4'h1, 32'd0, 32'd0);
    doPkt("R4", 11, 12, 0, 0, 0);
    // R10 raw mode ignores reserved mode
    setCtx(12, 10'h2C4, 0, 8'h12, 7, 4'h2, 32'd3, 32'd3);
    doPkt("R10", 12, 12, 0, 1, 24'hABCDEF);
    // R11 counter wrap and carry, with substitution in same packet
    setCtx(13, 10'h013, 0, 8'h13, 0, 4'h0, 32'h0000_FFF0, 32'hFFFF_FFFF);
    doPkt("R11", 13, 32, 0, 0, 0);
    // R3 length bounds, R2 last channel
    setCtx(127, 10'h37F, 0, 8'hFF, 4, 4'h9, 32'd0, 32'd0);
    doPkt("R3", 127, 64, 0, 0, 0);
    doPkt("R2", 127, 1, 0, 0, 0);
    // R9 reserved mode drops and sticks
    setCtx(14, 10'h014, 0, 8'h14, 6, 4'h1, 32'd7, 32'd7);
    doPkt("R9", 14, 4, 0, 0, 0);
    doPkt("R9", 3, 4, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule